// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits behind the receive side of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept or thrown away. The MAC streams the six destination-address bytes of the frame in wire order and presents the total frame length alongside them. One cycle after the sixth byte, the filter emits a single-cycle decision pulse that carries accept or reject.

The decision combines several checks. Unicast frames must match one programmed station address. Broadcast frames pass unless broadcast rejection is set. Other group-address frames must hit one of four programmable multicast entries, unless multicast rejection is set. Promiscuous mode accepts every address. Independently of the address, a frame-size rule drops frames of 1519 to 1522 bytes when neither jumbo nor VLAN-tagged frames are allowed.

Accepted frames are tallied in 64-bit byte, frame, broadcast and multicast counters. Rejected frames set a sticky reject status bit, which software clears. Configuration is loaded through a simple word-wide write port.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset, dec_valid and rej_status are 0 and all four counters are 0. All configuration is 0, so the station address is 00:00:00:00:00:00 and a unicast frame to that address with a legal length is accepted.
- R2: The station address is loaded through two registers. Address 1 holds destination bytes 0..3, with byte 0 in bits 7:0. Address 2 bits 15:0 hold bytes 4 and 5, with byte 4 in bits 7:0. A frame whose byte 0 bit 0 is 0 is accepted only when all six bytes equal this address.
- R3: A destination of all ones is a broadcast. It is accepted unless control register (address 0) bit 2 is set. It is not affected by multicast rejection or by the multicast table.
- R4: A non-broadcast destination whose byte 0 bit 0 is 1 is rejected when control bit 3 is set. Otherwise it is accepted only if it equals one of the four multicast entries.
- R5: Bits 1:0 of the index register (address 3) select one multicast entry. Writes to address 4 load that entry's bytes 0..3 and writes to address 5 load its bytes 4..5, in the same layout as R2. The other entries keep their contents.
- R6: When bit 31 of the index register is set, every destination address is accepted.
- R7: When control bit 0 (jumbo) is 0 and control bit 1 (VLAN) is 0, a frame of length 1519 to 1522 is rejected. This happens whatever its address, including in promiscuous mode. Lengths of 1518 and 1523 are not affected by this rule, and setting either control bit removes the rule.
- R8: Bytes are taken while in_valid is 1, and in_sof marks byte 0. The decision pulse (dec_valid with dec_accept) appears for exactly one cycle, in the cycle after the sixth byte is sampled. A new in_sof restarts collection, and bytes after the sixth produce no further decision.
- R9: At the same edge that raises the decision, an accepted frame adds in_len (sampled with the sixth byte) to cnt_bytes and 1 to cnt_frames. It also adds 1 to cnt_bcast for a broadcast, or to cnt_mcast for any other group address. A rejected frame changes no counter.
- R10: A rejected frame sets rej_status, which stays set until a write to address 6 with bit 0 set clears it. When both happen at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Address byte valid |
| in_sof | input | 1 | Marks destination byte 0 |
| in_data | input | 8 | Destination address byte |
| in_len | input | 16 | Frame length in bytes, sampled with the sixth byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | 1 = accepted, 0 = rejected; valid with dec_valid |
| rej_status | output | 1 | Sticky reject status |
| cnt_bytes | output | 64 | Accepted byte count |
| cnt_frames | output | 64 | Accepted frame count |
| cnt_bcast | output | 64 | Accepted broadcast frame count |
| cnt_mcast | output | 64 | Accepted multicast frame count |

## Verification
The decision, the counters and the reject status all come from flops that load at the edge which samples the sixth address byte. The bench therefore drives on falling edges and reads every one of these results 1 ns after that rising edge. One edge later it checks that the pulse has dropped and that trailing bytes give no second decision. A register write is driven on a falling edge and takes effect at the next rising edge, so it governs any frame whose first byte follows it.

// File: rtl/efilt_pkg.sv
package efilt_pkg;
  localparam int MAC_W     = 48;
  localparam int LEN_W     = 16;
  localparam int STD_MAX   = 1518;
  localparam int VLAN_MAX  = 1522;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_UC_LO  = 3'd1,
    RA_UC_HI  = 3'd2,
    RA_INDEX  = 3'd3,
    RA_MC_LO  = 3'd4,
    RA_MC_HI  = 3'd5,
    RA_RJ_CLR = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic             promisc;
    logic             jumbo;
    logic             vlan;
    logic             bc_rej;
    logic             mc_rej;
    logic [MAC_W-1:0] ucast;
  } filt_cfg_t;
endpackage

// File: rtl/efilt_regs.sv
module efilt_regs
  import efilt_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  localparam int SEL_W = (MC_ENTRIES > 1) ? $clog2(MC_ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [2:0]            waddr,
  input  logic [31:0]           wdata,
  output filt_cfg_t             cfg,
  output logic [MAC_W-1:0]      mc_tab [MC_ENTRIES],
  output logic                  rj_clr
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      sel_q <= '0;
    end else if (we) begin
      case (waddr)
        RA_CTRL: begin
          cfg.jumbo  <= wdata[0];
          cfg.vlan   <= wdata[1];
          cfg.bc_rej <= wdata[2];
          cfg.mc_rej <= wdata[3];
        end
        RA_UC_LO: cfg.ucast[31:0]     <= wdata;
        RA_UC_HI: cfg.ucast[47:32]    <= wdata[15:0];
        RA_INDEX: begin
          cfg.promisc <= wdata[31];
          sel_q       <= wdata[SEL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  for (genvar e = 0; e < MC_ENTRIES; e++) begin : g_mc
    always_ff @(posedge clk) begin
      if (rst) begin
        mc_tab[e] <= '0;
      end else if (we && sel_q == SEL_W'(e)) begin
        if (waddr == RA_MC_LO) mc_tab[e][31:0]  <= wdata;
        if (waddr == RA_MC_HI) mc_tab[e][47:32] <= wdata[15:0];
      end
    end
  end

  assign rj_clr = we && (waddr == RA_RJ_CLR) && wdata[0];
endmodule

// File: rtl/efilt_collect.sv
module efilt_collect
  import efilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int POS_W = $clog2(ADDR_BYTES + 1),
  localparam int HOLD_W = (ADDR_BYTES - 1) * 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic [7:0]                in_data,
  output logic                      last,
  output logic [ADDR_BYTES*8-1:0]   dest
);
  localparam logic [POS_W-1:0] IDLE = POS_W'(ADDR_BYTES);
  localparam logic [POS_W-1:0] LAST = POS_W'(ADDR_BYTES - 1);

  logic [POS_W-1:0]  pos_q;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= IDLE;
      hold_q <= '0;
    end else if (in_valid) begin
      if (in_sof) begin
        hold_q[7:0] <= in_data;
        pos_q       <= POS_W'(1);
      end else if (pos_q != IDLE) begin
        if (pos_q == LAST) begin
          pos_q <= IDLE;
        end else begin
          hold_q[int'(pos_q)*8 +: 8] <= in_data;
          pos_q <= pos_q + POS_W'(1);
        end
      end
    end
  end

  assign last = in_valid && !in_sof && (pos_q == LAST);
  assign dest = {in_data, hold_q};
endmodule

// File: rtl/efilt_decide.sv
module efilt_decide
  import efilt_pkg::*;
#(
  parameter int MC_ENTRIES = 4
) (
  input  logic [MAC_W-1:0] dest,
  input  logic [LEN_W-1:0] len,
  input  filt_cfg_t        cfg,
  input  logic [MAC_W-1:0] mc_tab [MC_ENTRIES],
  output logic             accept,
  output logic             is_bc,
  output logic             is_mc
);
  logic [MC_ENTRIES-1:0] hit;
  logic len_bad, addr_ok;

  for (genvar e = 0; e < MC_ENTRIES; e++) begin : g_hit
    assign hit[e] = (dest == mc_tab[e]);
  end

  assign is_bc = &dest;
  assign is_mc = dest[0] && !is_bc;
  assign len_bad = !cfg.jumbo && !cfg.vlan &&
                   (len > LEN_W'(STD_MAX)) && (len <= LEN_W'(VLAN_MAX));

  always_comb begin
    if (cfg.promisc)   addr_ok = 1'b1;
    else if (is_bc)    addr_ok = !cfg.bc_rej;
    else if (is_mc)    addr_ok = !cfg.mc_rej && (|hit);
    else               addr_ok = (dest == cfg.ucast);
  end

  assign accept = !len_bad && addr_ok;
endmodule

// File: rtl/efilt_stats.sv
module efilt_stats
  import efilt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             is_bc,
  input  logic             is_mc,
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] bytes,
  output logic [CNT_W-1:0] frames,
  output logic [CNT_W-1:0] bcast,
  output logic [CNT_W-1:0] mcast
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bytes  <= '0;
      frames <= '0;
      bcast  <= '0;
      mcast  <= '0;
    end else if (take) begin
      bytes  <= bytes + CNT_W'(len);
      frames <= frames + CNT_W'(1);
      if (is_bc) bcast <= bcast + CNT_W'(1);
      if (is_mc) mcast <= mcast + CNT_W'(1);
    end
  end
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import efilt_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  parameter int CNT_W      = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic [LEN_W-1:0] in_len,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             rej_status,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_mcast
);
  localparam int ADDR_BYTES = MAC_W / 8;

  filt_cfg_t        cfg;
  logic [MAC_W-1:0] mc_tab [MC_ENTRIES];
  logic             rj_clr, last, accept, is_bc, is_mc;
  logic [MAC_W-1:0] dest;

  efilt_regs #(.MC_ENTRIES(MC_ENTRIES)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .cfg(cfg), .mc_tab(mc_tab), .rj_clr(rj_clr)
  );

  efilt_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .last(last), .dest(dest)
  );

  efilt_decide #(.MC_ENTRIES(MC_ENTRIES)) u_decide (
    .dest(dest), .len(in_len), .cfg(cfg), .mc_tab(mc_tab),
    .accept(accept), .is_bc(is_bc), .is_mc(is_mc)
  );

  efilt_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .take(last && accept), .is_bc(is_bc), .is_mc(is_mc),
    .len(in_len), .bytes(cnt_bytes), .frames(cnt_frames),
    .bcast(cnt_bcast), .mcast(cnt_mcast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      rej_status <= 1'b0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last && accept;
      if (last && !accept) rej_status <= 1'b1;
      else if (rj_clr)     rej_status <= 1'b0;
    end
  end
endmodule

// File: rtl/efilt_chk.sv
module efilt_chk
  import efilt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [LEN_W-1:0] in_len,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic             rej_status,
  input logic [CNT_W-1:0] cnt_bytes,
  input logic [CNT_W-1:0] cnt_frames,
  input logic [CNT_W-1:0] cnt_bcast,
  input logic [CNT_W-1:0] cnt_mcast
);
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid); // R8
  AST_REJ_FLAG: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_accept) |-> rej_status); // R10
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_accept) |-> cnt_frames == $past(cnt_frames) + CNT_W'(1)); // R9
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_accept) |-> cnt_bytes == $past(cnt_bytes) + CNT_W'($past(in_len))); // R9
  AST_REJ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(dec_valid && dec_accept) |-> ($stable(cnt_frames) && $stable(cnt_bytes))); // R9
  AST_CLASS_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cnt_bcast <= cnt_frames) && (cnt_mcast <= cnt_frames)); // R9
endmodule

bind eth_rx_filter efilt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_len(in_len), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .rej_status(rej_status), .cnt_bytes(cnt_bytes),
  .cnt_frames(cnt_frames), .cnt_bcast(cnt_bcast), .cnt_mcast(cnt_mcast)
);

// File: tb/eth_rx_filter_tb.sv
module eth_rx_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] in_len = '0;
  logic        dec_valid, dec_accept, rej_status;
  logic [63:0] cnt_bytes, cnt_frames, cnt_bcast, cnt_mcast;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  bit        m_jumbo, m_vlan, m_bcrej, m_mcrej, m_promisc, m_rej;
  bit [1:0]  m_sel;
  bit [47:0] m_uc;
  bit [47:0] m_mc [4];
  bit [63:0] m_bytes, m_frames, m_bc, m_mc_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_filter u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .in_len(in_len), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .rej_status(rej_status), .cnt_bytes(cnt_bytes),
    .cnt_frames(cnt_frames), .cnt_bcast(cnt_bcast), .cnt_mcast(cnt_mcast)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: begin m_jumbo = d[0]; m_vlan = d[1]; m_bcrej = d[2]; m_mcrej = d[3]; end
      3'd1: m_uc[31:0] = d;
      3'd2: m_uc[47:32] = d[15:0];
      3'd3: begin m_promisc = d[31]; m_sel = d[1:0]; end
      3'd4: m_mc[m_sel][31:0] = d;
      3'd5: m_mc[m_sel][47:32] = d[15:0];
      3'd6: if (d[0]) m_rej = 0;
      default: ;
    endcase
  endtask

  function automatic bit exp_accept(bit [47:0] dst, bit [15:0] len);
    if (!m_jumbo && !m_vlan && len > 1518 && len <= 1522) return 0;  // R7
    if (m_promisc) return 1;                                          // R6
    if (&dst) return !m_bcrej;                                        // R3
    if (dst[0]) begin                                                 // R4
      if (m_mcrej) return 0;
      for (int e = 0; e < 4; e++) if (dst == m_mc[e]) return 1;
      return 0;
    end
    return dst == m_uc;                                               // R2
  endfunction

  // junk: bytes of an abandoned start before the real in_sof; extra: bytes after the sixth
  task automatic send(bit [47:0] dst, bit [15:0] len, string req, int junk = 0, int extra = 0);
    bit acc;
    acc = exp_accept(dst, len);
    for (int j = 0; j < junk; j++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (j == 0); in_data = 8'(j + 8'h5a); in_len = len;
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_data = dst[i*8 +: 8]; in_len = len;
    end
    @(posedge clk); #1;
    if (acc) begin
      m_frames++; m_bytes += 64'(len);
      if (&dst) m_bc++; else if (dst[0]) m_mc_n++;
    end else m_rej = 1;
    chk({"R8 pulse ", req}, 64'(dec_valid), 64'd1);
    chk({req, " decision"}, 64'(dec_accept), 64'(acc));
    chk("R9 frames", cnt_frames, m_frames);
    chk("R9 bytes", cnt_bytes, m_bytes);
    chk("R9 bcast", cnt_bcast, m_bc);
    chk("R9 mcast", cnt_mcast, m_mc_n);
    chk("R10 status", 64'(rej_status), 64'(m_rej));
    for (int x = 0; x < extra; x++) begin
      @(negedge clk);
      in_valid = 1; in_sof = 0; in_data = 8'hff;
      @(posedge clk); #1;
      chk("R8 no decision on trailing byte", 64'(dec_valid), 64'd0);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    @(posedge clk); #1;
    chk("R8 one-cycle pulse", 64'(dec_valid), 64'd0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit [47:0] d;
    bit [15:0] l;
    bit [15:0] lens [8];
    process::self().srandom(32'd20240611);
    lens = '{16'd64, 16'd1518, 16'd1519, 16'd1520, 16'd1522, 16'd1523, 16'd9000, 16'd300};
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(posedge clk); #1;
    chk("R1 dec_valid", 64'(dec_valid), 0);
    chk("R1 rej_status", 64'(rej_status), 0);
    chk("R1 frames", cnt_frames, 0);
    chk("R1 bytes", cnt_bytes, 0);
    chk("R1 bcast", cnt_bcast, 0);
    chk("R1 mcast", cnt_mcast, 0);
    send(48'h0, 16'd64, "R1 zero station address");

    // R2 station address 02:11:22:33:44:55
    wr(3'd1, 32'h33221102);
    wr(3'd2, 32'h0000_5544);
    send(48'h554433221102, 16'd100, "R2 unicast match");
    send(48'h564433221102, 16'd100, "R2 unicast last byte differs");
    wr(3'd6, 32'h1);
    @(posedge clk); #1;
    chk("R10 cleared", 64'(rej_status), 0);

    // R3 broadcast ignores multicast reject, obeys broadcast reject
    wr(3'd0, 32'h8);
    send(48'hffffffffffff, 16'd64, "R3 broadcast with mcast reject");
    wr(3'd0, 32'h4);
    send(48'hffffffffffff, 16'd64, "R3 broadcast rejected");

    // R5/R4 table loading through index
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h2);
    wr(3'd4, 32'h005e0001);
    wr(3'd5, 32'h0000_0700);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h00aabb03);
    wr(3'd5, 32'h0000_0102);
    send(48'h0700005e0001, 16'd80, "R5 entry 2 hit");
    send(48'h0102_00aabb03, 16'd80, "R5 entry 0 hit");
    send(48'h0800005e0001, 16'd80, "R4 multicast miss");
    wr(3'd0, 32'h8);
    send(48'h0700005e0001, 16'd80, "R4 mcast reject over hit");

    // R6 promiscuous, R7 applies in promiscuous too
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h8000_0000);
    send(48'h123456789a00, 16'd64, "R6 promisc foreign unicast");
    send(48'h123456789a01, 16'd64, "R6 promisc foreign multicast");
    send(48'h123456789a00, 16'd1519, "R7 promisc length band");
    wr(3'd3, 32'h0);

    // R7 length band edges
    send(48'h554433221102, 16'd1518, "R7 len 1518");
    send(48'h554433221102, 16'd1519, "R7 len 1519");
    send(48'h554433221102, 16'd1522, "R7 len 1522");
    send(48'h554433221102, 16'd1523, "R7 len 1523");
    wr(3'd0, 32'h2);
    send(48'h554433221102, 16'd1520, "R7 vlan allows 1520");
    wr(3'd0, 32'h1);
    send(48'h554433221102, 16'd1521, "R7 jumbo allows 1521");

    // R8 restart on new sof and trailing bytes
    send(48'h554433221102, 16'd64, "R8 restart after partial", 3, 0);
    send(48'h554433221102, 16'd64, "R8 trailing bytes", 0, 3);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 25 == 0) begin
        wr(3'd0, $urandom & 32'hf);
        wr(3'd3, (($urandom % 5 == 0) ? 32'h8000_0000 : 32'h0) | ($urandom & 32'h3));
        wr(3'd4, {$urandom} | 32'h1);
        wr(3'd5, $urandom);
      end
      case ($urandom % 6)
        0: d = m_uc;
        1: begin d = m_uc; d[40 +: 8] ^= 8'h10; end
        2: d = 48'hffffffffffff;
        3: d = m_mc[$urandom % 4];
        4: d = {16'($urandom), $urandom} | 48'h1;
        default: d = {16'($urandom), $urandom} & ~48'h1;
      endcase
      if ($urandom % 2 == 0) l = lens[$urandom % 8];
      else l = 16'(60 + $urandom % 1600);
      send(d, l, "R2-mix random frame");
      if ($urandom % 8 == 0) begin
        wr(3'd6, 32'h1);
        @(posedge clk); #1;
        chk("R10 clear", 64'(rej_status), 0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule